// File: doc/BRIEF.md
# Serial Converter Frame and Power-State Controller

This block is the digital side of a three-wire serial successive-approximation converter. Its clock is the host's serial clock. An active-low start line begins each frame. The block holds the sampler, counts the clock edges of a 16-edge frame and shifts a 12-bit result out on a data line that can be released to high impedance. The analog part resolves the result and presents it on a parallel input. Each bit of that input is taken at the edge that shifts it out.

The point at which the host raises the start line also selects the power state. Four states exist: normal, light sleep, deep sleep and waking. Deep sleep is reached only from light sleep, by a second early release. A long enough low period wakes the part from either sleep state. An initialization flag models the calibration frame that follows hardware power-up. The frame interface carries no data stream, so every pin is a plain level. The host paces the frames itself and there is no back-pressure.

Top module: `sadc_serial_ctrl`

"Edge index" below means the number of clock rising edges after the edge that first samples `start_n` low. That first edge has index 0. A release "at index k" means that the edge sampling `start_n` high again finds k edges already counted. `pwr_mode` encodes normal = 00, light sleep = 01, deep sleep = 10, waking = 11.

## Requirements
- R1: After reset the outputs read `track`=1, `dout_oe`=0, `dout`=0, `pwr_mode`=00 and `initialized`=0.
- R2: The edge that samples `start_n` low after high puts `track` at 0 and `dout_oe` at 1, with `dout`=0, from that edge on.
- R3: After edges 1 to 3 `dout` is 0. After edge n (n = 4..15) it carries `sar_code[15-n]`, so the MSB comes first. After edge 16 it is 0.
- R4: `track` returns to 1 after edge 14. The edge count stops at 16, and further clocks change neither `track` nor the frame position.
- R5: A release at index 14 or 15 lets the frame finish its bits. `dout_oe` then stays 1 with `dout`=0 until the next frame.
- R6: If `start_n` is still low when the count has reached 16, the next edge clears `dout_oe`. A release at index 16 has the same effect.
- R7: From normal, a release at index 3..13 enters light sleep (01) and clears `dout_oe` at once. A release at index 0..2 aborts the frame: `dout_oe` clears, `track` returns to 1 and the mode does not change.
- R8: From light sleep, a release at index 3..13 enters deep sleep (10). A release at 0..2 leaves it in light sleep.
- R9: A frame started in deep sleep shows waking (11). A release at index 14 or later returns to normal, and a release before index 14 drops back to deep sleep. A release at 14 or later in light sleep also returns to normal.
- R10: A frame started in any mode other than normal shifts out 0 on every bit, whatever `sar_code` holds.
- R11: `initialized` rises after edge 14 of the first frame after reset. It is cleared only by reset and stays 1 through the sleep states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| start_n | input | 1 | Active-low frame start / release line |
| sar_code | input | 12 | Result bits from the converter core, straight binary |
| track | output | 1 | 1 = sampler tracking, 0 = holding |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | 1 = data line driven, 0 = high impedance |
| pwr_mode | output | 2 | Power state: 00 normal, 01 light, 10 deep, 11 waking |
| initialized | output | 1 | First frame after reset has passed edge 14 |

## Verification
Two events can land on the same clock edge. The release of `start_n` can arrive at the edge where `track` would rise, at index 13 versus 14, and that choice decides between a power-down abort and a gap-free continuous frame. A restart can also arrive at index 15, where the trailing zero and the next frame's first low compete. Both are provoked by sweeping the release and restart index across these boundaries. A behavioural model judges every cycle: it tracks frame position, mode and drive state as integers and compares them against all outputs.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_LIGHT  = 2'b01,
    PM_DEEP   = 2'b10,
    PM_WAKE   = 2'b11
  } pmode_e;
endpackage

// File: rtl/sadc_frame_ctr.sv
module sadc_frame_ctr #(
  parameter int FRAME_LEN = 16,
  parameter int PD_FROM   = 3,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  output logic             start_fall,
  output logic             start_rise,
  output logic             abort,
  output logic [CNT_W-1:0] pos,
  output logic             keep,
  output logic             track,
  output logic             initialized
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] TRK_AT = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] PD_LO  = CNT_W'(PD_FROM);

  logic start_q;

  assign start_fall = start_q & ~start_n;
  assign start_rise = ~start_q & start_n;
  assign abort      = start_rise & (pos < TRK_AT);
  assign track      = (pos >= TRK_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q     <= 1'b1;
      pos         <= LAST;
      keep        <= 1'b0;
      initialized <= 1'b0;
    end else begin
      start_q <= start_n;
      if (start_fall) begin
        pos  <= '0;
        keep <= 1'b0;
      end else if (abort) begin
        pos <= LAST;
      end else begin
        if (pos < LAST) pos <= pos + 1'b1;
        if (start_rise && pos < LAST) keep <= 1'b1;
        if (pos == TRK_AT - 1'b1) initialized <= 1'b1;
      end
    end
  end

  // R4: count saturates at the frame length
  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);
  // R4: once saturated, only a new start moves the count
  p_count_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST && !start_fall) |=> pos == LAST);
  // R11: flag is sticky
  p_init_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    initialized |=> initialized);
  // R7: an early release sends the sampler back to tracking
  p_abort_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && pos < PD_LO) |=> track);
endmodule

// File: rtl/sadc_power_fsm.sv
module sadc_power_fsm
  import sadc_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int PD_FROM   = 3,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fall,
  input  logic             start_rise,
  input  logic [CNT_W-1:0] pos,
  output pmode_e           mode,
  output logic             frame_pd
);
  localparam logic [CNT_W-1:0] TRK_AT = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] PD_LO  = CNT_W'(PD_FROM);

  pmode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    if (start_fall) begin
      if (mode == PM_DEEP) mode_nx = PM_WAKE;
    end else if (start_rise) begin
      if (pos >= TRK_AT) begin
        mode_nx = PM_NORMAL;
      end else if (pos >= PD_LO) begin
        mode_nx = (mode == PM_NORMAL) ? PM_LIGHT : PM_DEEP;
      end else if (mode == PM_WAKE) begin
        mode_nx = PM_DEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= PM_NORMAL;
      frame_pd <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (start_fall) frame_pd <= (mode != PM_NORMAL);
    end
  end

  // R8: deep sleep is never entered straight from normal
  p_no_direct_deep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NORMAL) |=> (mode != PM_DEEP));
  // R9: waking is only entered from deep sleep
  p_wake_from_deep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NORMAL || mode == PM_LIGHT) |=> (mode != PM_WAKE));
  // R9: a long low period always ends in normal
  p_long_low_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && pos >= TRK_AT) |=> mode == PM_NORMAL);
endmodule

// File: rtl/sadc_shift_out.sv
module sadc_shift_out #(
  parameter int RES_W      = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int FRAME_LEN  = 16,
  parameter int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fall,
  input  logic             abort,
  input  logic [CNT_W-1:0] pos,
  input  logic             keep,
  input  logic             frame_pd,
  input  logic [RES_W-1:0] code_in,
  output logic             dout,
  output logic             dout_oe
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN);
  localparam int               FIRST_D  = LEAD_ZEROS + 1;
  localparam int               LAST_D   = LEAD_ZEROS + RES_W;
  localparam int               IDX_W    = $clog2(RES_W);

  logic [CNT_W-1:0] nxt;
  logic             bit_nx;
  int               idx;

  assign nxt = pos + 1'b1;

  always_comb begin
    bit_nx = 1'b0;
    idx    = LAST_D - int'(nxt);
    if (!frame_pd && int'(nxt) >= FIRST_D && int'(nxt) <= LAST_D)
      bit_nx = code_in[idx[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (start_fall) begin
      dout    <= 1'b0;
      dout_oe <= 1'b1;
    end else if (abort) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (pos == LAST) begin
      dout    <= 1'b0;
      dout_oe <= dout_oe & keep;
    end else begin
      dout <= bit_nx;
    end
  end

  // R2: a start drives the line low on the next cycle
  p_start_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall |=> (dout_oe && !dout));
  // R10: frames begun while asleep carry only zeros
  p_sleep_frame_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pd |-> !dout);
  // R6: without a continuation request the line is released after the frame
  p_release_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST && !keep && !start_fall) |=> !dout_oe);
endmodule

// File: rtl/sadc_serial_ctrl.sv
module sadc_serial_ctrl
  import sadc_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int TAIL_ZEROS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic [RES_W-1:0] sar_code,
  output logic             track,
  output logic             dout,
  output logic             dout_oe,
  output logic [1:0]       pwr_mode,
  output logic             initialized
);
  localparam int FRAME_LEN = LEAD_ZEROS + RES_W + TAIL_ZEROS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic             start_fall, start_rise, abort, keep, frame_pd;
  logic [CNT_W-1:0] pos;
  pmode_e           mode;

  sadc_frame_ctr #(.FRAME_LEN(FRAME_LEN), .PD_FROM(LEAD_ZEROS), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start_n(start_n),
    .start_fall(start_fall), .start_rise(start_rise), .abort(abort),
    .pos(pos), .keep(keep), .track(track), .initialized(initialized)
  );

  sadc_power_fsm #(.FRAME_LEN(FRAME_LEN), .PD_FROM(LEAD_ZEROS), .CNT_W(CNT_W)) u_pwr (
    .clk(clk), .rst_n(rst_n), .start_fall(start_fall), .start_rise(start_rise),
    .pos(pos), .mode(mode), .frame_pd(frame_pd)
  );

  sadc_shift_out #(.RES_W(RES_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN),
                   .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .start_fall(start_fall), .abort(abort),
    .pos(pos), .keep(keep), .frame_pd(frame_pd), .code_in(sar_code),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign pwr_mode = mode;

  // R7: entering light sleep releases the line
  p_sleep_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && !start_fall) ##1 (pwr_mode == 2'b01) |-> !dout_oe);
  // R2: holding while a frame is under way
  p_hold_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall |=> !track);
endmodule

// File: tb/sadc_serial_ctrl_tb_top.sv
module sadc_serial_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_n = 1'b1;
  logic [11:0] sar_code = '0;
  logic        track, dout, dout_oe, initialized;
  logic [1:0]  pwr_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_pos, m_mode;
  bit m_sq, m_keep, m_oe, m_dout, m_pd, m_init;

  always #2 clk = ~clk;

  sadc_serial_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .sar_code(sar_code),
    .track(track), .dout(dout), .dout_oe(dout_oe), .pwr_mode(pwr_mode),
    .initialized(initialized)
  );

  task automatic model_reset();
    m_pos = 16; m_mode = 0; m_sq = 1; m_keep = 0;
    m_oe = 0; m_dout = 0; m_pd = 0; m_init = 0;
  endtask

  task automatic compare();
    bit exp_trk;
    exp_trk = (m_pos >= 14);
    n_chk++;
    if (track !== exp_trk || dout_oe !== m_oe || dout !== m_dout ||
        pwr_mode !== 2'(m_mode) || initialized !== m_init) begin
      n_fail++;
      $display("FAIL %s: got trk=%0b oe=%0b d=%0b mode=%0d init=%0b exp trk=%0b oe=%0b d=%0b mode=%0d init=%0b",
               tag, track, dout_oe, dout, pwr_mode, initialized,
               exp_trk, m_oe, m_dout, m_mode, m_init);
    end
  endtask

  // next state for the coming rising edge, given inputs s and c
  task automatic model_edge(bit s, logic [11:0] c);
    bit fall, rise;
    fall = m_sq && !s;
    rise = !m_sq && s;
    if (fall) begin
      m_pos = 0; m_keep = 0; m_oe = 1; m_dout = 0;
      m_pd = (m_mode != 0);
      if (m_mode == 2) m_mode = 3;
    end else if (rise && m_pos < 14) begin
      if (m_pos >= 3) m_mode = (m_mode == 0) ? 1 : 2;
      else if (m_mode == 3) m_mode = 2;
      m_oe = 0; m_dout = 0; m_pos = 16;
    end else begin
      if (rise) begin
        m_mode = 0;
        if (m_pos < 16) m_keep = 1;
      end
      if (m_pos == 16) begin
        if (!m_keep) m_oe = 0;
        m_dout = 0;
      end else begin
        if (m_pos == 13) m_init = 1;
        m_pos++;
        m_dout = (!m_pd && m_pos >= 4 && m_pos <= 15) ? c[15 - m_pos] : 1'b0;
      end
    end
    m_sq = s;
  endtask

  task automatic step(bit s, logic [11:0] c);
    @(negedge clk);
    compare();
    start_n = s;
    sar_code = c;
    model_edge(s, c);
  endtask

  // start, hold low for (rel+1) samples (release seen at index rel), then high
  task automatic frame(string t, logic [11:0] c, int rel, int hi);
    tag = t;
    for (int i = 0; i <= rel; i++) step(1'b0, c);
    for (int i = 0; i < hi; i++) step(1'b1, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start_n = 1;
    model_reset();
    @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    do_reset();
    tag = "R1"; step(1'b1, 12'h000); step(1'b1, 12'h000);
    // single frame held past its end
    frame("R2 R3 R4 R6 R11", 12'hA5C, 19, 3);
    frame("R3 R6 release at 16", 12'h3C1, 16, 3);
    // continuous frames
    frame("R5 release at 14", 12'hFFF, 14, 1);
    frame("R5 release at 15", 12'h801, 15, 2);
    frame("R5 restart at 15", 12'h555, 14, 0);
    frame("R5 R6 back-to-back", 12'h2AA, 18, 2);
    // aborts and sleep entry boundaries
    frame("R7 abort at 2", 12'hFFF, 2, 3);
    frame("R7 abort at 0", 12'hFFF, 0, 3);
    frame("R7 light at 3", 12'hFFF, 3, 4);
    frame("R8 R10 light abort at 2", 12'hFFF, 2, 3);
    frame("R8 R10 deep at 13", 12'hFFF, 13, 4);
    frame("R9 R10 wake short", 12'hFFF, 10, 3);
    frame("R9 R10 wake abort", 12'hFFF, 1, 3);
    frame("R9 R10 R11 wake long", 12'hFFF, 15, 3);
    frame("R3 after wake", 12'h9E7, 20, 2);
    frame("R7 light at 13", 12'h123, 13, 3);
    frame("R9 light wake at 14", 12'hFFF, 14, 3);
    frame("R3 R5 after light wake", 12'hC3A, 17, 2);
    // reset mid-frame clears the flag, first frame re-initializes
    tag = "R1";
    step(1'b0, 12'h0F0); step(1'b0, 12'h0F0); step(1'b0, 12'h0F0);
    do_reset();
    frame("R11 short then full", 12'h0F0, 8, 2);
    frame("R11 deep first", 12'h0F0, 5, 2);
    frame("R11 wake init", 12'h0F0, 16, 2);
    for (int k = 0; k < 40; k++) begin
      logic [11:0] c;
      c = 12'((k * 12'h2B7) ^ (k << 5));
      frame("R3 R5 sweep", c, 14 + (k % 5), k % 3);
    end
    tag = "R4"; for (int i = 0; i < 4; i++) step(1'b1, 12'hFFF);
    @(negedge clk); compare();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule